// File: doc/BRIEF.md
# Real-Time Clock Update Sequencer and Register Port

This block sits between a host and a calendar counter. The host reaches it through a two-address port. An access to the index address picks a register. Each later access to the data address reads or writes the register that was picked.

The time fields belong to a separate calendar counter. This block passes those accesses through to it over a small field interface. The block itself holds the divider/rate register, the mode register and the power-status register.

A prescaler counts a 32768 Hz enable. Once every second it produces a one-cycle update strobe for the calendar counter. An update-in-progress flag brackets every strobe, so software can tell when the time fields are unsafe to read. Software can freeze updates while it loads a new time. It can also hold the prescaler in reset, and releasing that reset places the first update half a second later.

Top module: `rtc_update_ctrl`

## Requirements
- R1: A data-port read returns the selected register on `bus_rdata` with `bus_rvalid` high in the cycle after the read strobe. The selection is made by the low 7 bits of the last index-port write (`bus_addr`=0 is the index port, 1 is the data port). After reset all outputs are 0.
- R2: Bit 7 of an index-port write drives `nmi_mask` from the next cycle on (1 masks, 0 unmasks) and plays no part in register selection.
- R3: Indices 0, 2, 4, 6, 7, 8 and 9 are time fields.
  - A data write to one of them gives a one-cycle `fld_wr` pulse in the next cycle, with `fld_wdata` and `fld_addr` set to the index.
  - A data read of one of them returns `fld_rdata`.
  - Any other index not named in R4 to R6 reads 0, and writes to it are dropped.
- R4: Index 10 is the divider register.
  - Bits 6..0 are read/write, and reset to 0x26.
  - Bit 7 reads the update-in-progress flag, and writes to bit 7 are ignored.
  - Bits 6..4 form the divider code.
- R5: Index 11 is the mode register. All 8 bits are read/write and it resets to 0x02. Bit 7 is the freeze bit.
- R6: Index 13 is the power-status register and is read-only.
  - Bit 7 reads 1 when `pwr_good` has stayed high since the previous read of index 13, and 0 otherwise.
  - Bits 6..0 read 0, and writes to index 13 are ignored.
- R7: With divider code 010, `upd_strobe` pulses once every TICKS_PER_SEC `ref_tick` pulses.
- R8: `uip` rises UIP_LEAD ticks before each `upd_strobe` and falls UIP_HOLD ticks after it. `upd_strobe` lasts one cycle.
- R9: While the freeze bit is 1, neither `upd_strobe` nor `uip` is asserted, and the prescaler keeps counting. Once the bit is cleared, updates resume on the original one-second grid.
- R10: Divider code 111 holds the prescaler at its half-second point with `uip` and `upd_strobe` low. The first strobe comes TICKS_PER_SEC/2 ticks after code 010 is written.
- R11: Any divider code other than 010 and 111 pauses the prescaler without resetting it. After a return to 010 the count resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable at the 32768 Hz time-base rate |
| pwr_good | input | 1 | Clock power is good (synchronous) |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a data read |
| nmi_mask | output | 1 | Non-maskable-interrupt mask from index bit 7 |
| fld_addr | output | 4 | Selected time-field index |
| fld_wr | output | 1 | Time-field write pulse |
| fld_wdata | output | 8 | Time-field write data |
| fld_rdata | input | 8 | Time-field read data from the calendar counter |
| upd_strobe | output | 1 | One-cycle once-per-second update pulse |
| uip | output | 1 | Update-in-progress flag |

## Verification
The assertions rely on a few properties of the inputs:
- `ref_tick` is a clean enable sampled on the same clock.
- `bus_wr` and `bus_rd` are never asserted together.
- `pwr_good` is already synchronous.
- TICKS_PER_SEC exceeds UIP_LEAD plus UIP_HOLD, so a strobe can never follow another strobe.

The bench drives every input from negative-edge tasks and keeps `ref_tick` high on every cycle, so that tick counts equal cycle counts. It issues each host access as a single-cycle strobe with one port selected. It changes the divider and freeze bits only through ordinary register writes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int IDX_W = 7;
  localparam int DAT_W = 8;

  localparam logic [IDX_W-1:0] IX_DIV  = 7'd10;
  localparam logic [IDX_W-1:0] IX_MODE = 7'd11;
  localparam logic [IDX_W-1:0] IX_PWR  = 7'd13;

  localparam logic [2:0] DV_RUN = 3'b010;
  localparam logic [2:0] DV_RST = 3'b111;

  localparam logic [DAT_W-1:0] DIV_RST_VAL  = 8'h26;
  localparam logic [DAT_W-1:0] MODE_RST_VAL = 8'h02;

  function automatic logic is_time_idx(input logic [IDX_W-1:0] i);
    case (i)
      7'd0, 7'd2, 7'd4, 7'd6, 7'd7, 7'd8, 7'd9: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [DAT_W-1:0] bus_wdata,
  output logic [DAT_W-1:0] bus_rdata,
  output logic             bus_rvalid,
  output logic             nmi_mask,
  output logic [IDX_W-1:0] idx,
  output logic             reg_wr,
  output logic             reg_rd,
  input  logic [DAT_W-1:0] div_val,
  input  logic [DAT_W-1:0] mode_val,
  input  logic [DAT_W-1:0] pwr_val,
  output logic             fld_wr,
  output logic [DAT_W-1:0] fld_wdata,
  input  logic [DAT_W-1:0] fld_rdata
);
  logic             idx_wr;
  logic [DAT_W-1:0] rd_mux;

  assign idx_wr = bus_wr && !bus_addr;
  assign reg_wr = bus_wr && bus_addr;
  assign reg_rd = bus_rd && bus_addr;

  always_comb begin
    if (is_time_idx(idx))       rd_mux = fld_rdata;
    else if (idx == IX_DIV)     rd_mux = div_val;
    else if (idx == IX_MODE)    rd_mux = mode_val;
    else if (idx == IX_PWR)     rd_mux = pwr_val;
    else                        rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      nmi_mask   <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      fld_wr     <= 1'b0;
      fld_wdata  <= '0;
    end else begin
      bus_rvalid <= 1'b0;
      fld_wr     <= 1'b0;
      if (idx_wr) begin
        nmi_mask <= bus_wdata[DAT_W-1];
        idx      <= bus_wdata[IDX_W-1:0];
      end
      if (reg_wr && is_time_idx(idx)) begin
        fld_wr    <= 1'b1;
        fld_wdata <= bus_wdata;
      end
      if (reg_rd) begin
        bus_rvalid <= 1'b1;
        bus_rdata  <= rd_mux;
      end
    end
  end

  // R2: index-port bit 7 reaches the mask output one cycle later
  p_nmi_track_r2: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> (nmi_mask == $past(bus_wdata[DAT_W-1])));

  // R1: every data read is answered one cycle later
  p_rvalid_r1: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> bus_rvalid);

  // R3: field writes only for time indices
  p_fld_only_time_r3: assert property (@(posedge clk) disable iff (rst)
    fld_wr |-> is_time_idx($past(idx)));
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [IDX_W-1:0] idx,
  input  logic [DAT_W-1:0] wdata,
  input  logic             uip,
  input  logic             pwr_good,
  output logic [DAT_W-1:0] div_val,
  output logic [DAT_W-1:0] mode_val,
  output logic [DAT_W-1:0] pwr_val,
  output logic [2:0]       dv_code,
  output logic             freeze
);
  logic [DAT_W-2:0] div_q;
  logic [DAT_W-1:0] mode_q;
  logic             lost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= DIV_RST_VAL[DAT_W-2:0];
      mode_q <= MODE_RST_VAL;
      lost_q <= 1'b0;
    end else begin
      if (reg_wr && idx == IX_DIV)  div_q  <= wdata[DAT_W-2:0];
      if (reg_wr && idx == IX_MODE) mode_q <= wdata;
      if (!pwr_good)                         lost_q <= 1'b1;
      else if (reg_rd && idx == IX_PWR)      lost_q <= 1'b0;
    end
  end

  assign div_val  = {uip, div_q};
  assign mode_val = mode_q;
  assign pwr_val  = {!lost_q, {(DAT_W-1){1'b0}}};
  assign dv_code  = div_q[6:4];
  assign freeze   = mode_q[DAT_W-1];

  // R6: a power drop always shows in the next status value
  p_pwr_loss_r6: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> !pwr_val[DAT_W-1]);

  // R5: mode register changes only through a write to its index
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && idx == IX_MODE) |=> $stable(mode_val));
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8,
  parameter int UIP_HOLD      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic [2:0] dv_code,
  input  logic       freeze,
  output logic       upd_strobe,
  output logic       uip
);
  localparam int CW       = $clog2(TICKS_PER_SEC);
  localparam int HALF_PT  = TICKS_PER_SEC / 2;
  localparam int RISE_PT  = TICKS_PER_SEC - UIP_LEAD;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run, hold, wrap, in_win;

  assign run  = (dv_code == DV_RUN);
  assign hold = (dv_code == DV_RST);
  assign wrap = run && ref_tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (hold)                 cnt_d = CW'(HALF_PT);
    else if (run && ref_tick) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  assign in_win = (cnt_d >= CW'(RISE_PT)) || (cnt_d < CW'(UIP_HOLD));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= CW'(HALF_PT);
      upd_strobe <= 1'b0;
      uip        <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      upd_strobe <= wrap && !freeze;
      uip        <= !freeze && !hold && in_win;
    end
  end

  // R8: the strobe is a single-cycle pulse
  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |=> !upd_strobe);

  // R8: the strobe always falls inside the update window
  p_strobe_in_uip_r8: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> uip);

  // R9: freeze silences both outputs
  p_freeze_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    freeze |=> (!upd_strobe && !uip));

  // R10: divider reset silences both outputs
  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!upd_strobe && !uip));
endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8,
  parameter int UIP_HOLD      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       pwr_good,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_rvalid,
  output logic       nmi_mask,
  output logic [3:0] fld_addr,
  output logic       fld_wr,
  output logic [7:0] fld_wdata,
  input  logic [7:0] fld_rdata,
  output logic       upd_strobe,
  output logic       uip
);
  logic [IDX_W-1:0] idx;
  logic             reg_wr, reg_rd, freeze;
  logic [DAT_W-1:0] div_val, mode_val, pwr_val;
  logic [2:0]       dv_code;

  rtc_host_port u_port (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .nmi_mask(nmi_mask),
    .idx(idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .div_val(div_val), .mode_val(mode_val), .pwr_val(pwr_val),
    .fld_wr(fld_wr), .fld_wdata(fld_wdata), .fld_rdata(fld_rdata)
  );

  rtc_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .idx(idx),
    .wdata(bus_wdata), .uip(uip), .pwr_good(pwr_good),
    .div_val(div_val), .mode_val(mode_val), .pwr_val(pwr_val),
    .dv_code(dv_code), .freeze(freeze)
  );

  rtc_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .UIP_LEAD(UIP_LEAD), .UIP_HOLD(UIP_HOLD)
  ) u_pre (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .dv_code(dv_code),
    .freeze(freeze), .upd_strobe(upd_strobe), .uip(uip)
  );

  assign fld_addr = idx[3:0];
endmodule

// File: tb/rtc_update_ctrl_test.sv
module rtc_update_ctrl_test;
  localparam int TPS  = 32768;
  localparam int LEAD = 8;
  localparam int HOLD = 2;

  typedef struct packed {
    logic       wr;
    logic [6:0] idx;
    logic [7:0] dat;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  // R5 mode rw, R4 divider rw with bit 7 ignored, R3 time fields and
  // unused indices, R6 power status read-only
  localparam int NV = 20;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 7'd11,  8'h06, 8'h00, 4'd5},
    '{1'b0, 7'd11,  8'h00, 8'h06, 4'd5},
    '{1'b1, 7'd10,  8'h2F, 8'h00, 4'd4},
    '{1'b0, 7'd10,  8'h00, 8'h2F, 4'd4},
    '{1'b1, 7'd10,  8'hA6, 8'h00, 4'd4},
    '{1'b0, 7'd10,  8'h00, 8'h26, 4'd4},
    '{1'b1, 7'd0,   8'h45, 8'h00, 4'd3},
    '{1'b0, 7'd0,   8'h00, 8'h45, 4'd3},
    '{1'b1, 7'd9,   8'h99, 8'h00, 4'd3},
    '{1'b0, 7'd9,   8'h00, 8'h99, 4'd3},
    '{1'b1, 7'd7,   8'h31, 8'h00, 4'd3},
    '{1'b0, 7'd7,   8'h00, 8'h31, 4'd3},
    '{1'b1, 7'd3,   8'h55, 8'h00, 4'd3},
    '{1'b0, 7'd3,   8'h00, 8'h00, 4'd3},
    '{1'b1, 7'd13,  8'h00, 8'h00, 4'd6},
    '{1'b0, 7'd13,  8'h00, 8'h80, 4'd6},
    '{1'b1, 7'd12,  8'hFF, 8'h00, 4'd3},
    '{1'b0, 7'd12,  8'h00, 8'h00, 4'd3},
    '{1'b1, 7'd100, 8'h12, 8'h00, 4'd3},
    '{1'b0, 7'd100, 8'h00, 8'h00, 4'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b1;
  logic pwr_good = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, fld_wdata, fld_rdata;
  logic bus_rvalid, nmi_mask, fld_wr, upd_strobe, uip;
  logic [3:0] fld_addr;

  logic [7:0] cal [0:15];
  int checks = 0, errors = 0, cyc = 0, fld_wr_n = 0;
  int strobe_n = 0, last_strobe = 0, rise_cyc = 0, fall_cyc = 0;
  int dbl_strobe = 0, uip_hi = 0;
  logic uip_prev = 1'b0, strobe_prev = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_update_ctrl #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD), .UIP_HOLD(HOLD)) uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .pwr_good(pwr_good),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .nmi_mask(nmi_mask),
    .fld_addr(fld_addr), .fld_wr(fld_wr), .fld_wdata(fld_wdata),
    .fld_rdata(fld_rdata), .upd_strobe(upd_strobe), .uip(uip)
  );

  // calendar-counter model
  assign fld_rdata = cal[fld_addr];
  initial for (int i = 0; i < 16; i++) cal[i] = 8'h00;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fld_wr) begin
      cal[fld_addr] <= fld_wdata;
      fld_wr_n <= fld_wr_n + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (uip && !uip_prev) rise_cyc = cyc;
      if (!uip && uip_prev) fall_cyc = cyc;
      if (uip) uip_hi++;
      if (upd_strobe) begin strobe_n++; last_strobe = cyc; end
      if (upd_strobe && strobe_prev) dbl_strobe++;
    end
    uip_prev = uip;
    strobe_prev = upd_strobe;
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bwrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic rreg(input logic [6:0] ix, output logic [7:0] d);
    logic v;
    bwrite(1'b0, {1'b0, ix});
    bread(d, v);
    chk("R1", v, 1, "rvalid after read");
  endtask

  task automatic wreg(input logic [6:0] ix, input logic [7:0] d);
    bwrite(1'b0, {1'b0, ix});
    bwrite(1'b1, d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected below %0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    int t0, s1, s2, e1, e2, s3, uh;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", bus_rdata, 0, "reset rdata");
    chk("R1", bus_rvalid, 0, "reset rvalid");
    chk("R2", nmi_mask, 0, "reset nmi_mask");
    chk("R8", uip, 0, "reset uip");
    chk("R7", upd_strobe, 0, "reset strobe");
    chk("R3", fld_wr, 0, "reset fld_wr");
    rreg(7'd10, d); chk("R4", d, 8'h26, "divider reset value");
    rreg(7'd11, d); chk("R5", d, 8'h02, "mode reset value");

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].wr) wreg(VEC[k].idx, VEC[k].dat);
      else begin
        rreg(VEC[k].idx, d);
        chk($sformatf("R%0d", VEC[k].req), d, VEC[k].exp,
            $sformatf("read of index %0d", VEC[k].idx));
      end
    end
    chk("R3", fld_wr_n, 3, "field write pulses");
    chk("R3", cal[3], 0, "non-time index untouched");

    // R2 nmi mask bit does not change selection
    bwrite(1'b0, 8'h8B);
    chk("R2", nmi_mask, 1, "mask set");
    bread(d, v);
    chk("R2", d, 8'h06, "selection ignores bit 7");
    bwrite(1'b0, 8'h0B);
    chk("R2", nmi_mask, 0, "mask cleared");

    // R6 power loss
    pwr_good = 1'b0; @(negedge clk); pwr_good = 1'b1;
    rreg(7'd13, d); chk("R6", d, 8'h00, "status after power loss");
    rreg(7'd13, d); chk("R6", d, 8'h80, "status re-armed after read");

    // R10 divider reset then release
    wreg(7'd10, 8'h76);
    uh = uip_hi;
    repeat (100) @(negedge clk);
    chk("R10", uip_hi - uh, 0, "uip during divider reset");
    chk("R10", strobe_n, 0, "strobes during divider reset");
    wreg(7'd10, 8'h26);
    t0 = cyc;
    bwrite(1'b0, 8'h0A);
    while (rise_cyc <= t0) @(negedge clk);
    bread(d, v);
    chk("R4", d, 8'hA6, "divider read shows uip");
    while (strobe_n < 1) @(negedge clk);
    s1 = last_strobe;
    chk("R10", s1 - t0, TPS / 2, "first update after release");
    chk("R8", s1 - rise_cyc, LEAD, "uip lead");
    repeat (5) @(negedge clk);
    chk("R8", fall_cyc - s1, HOLD, "uip tail");
    while (strobe_n < 2) @(negedge clk);
    s2 = last_strobe;
    chk("R7", s2 - s1, TPS, "update period");

    // R11 pause with another divider code
    wreg(7'd10, 8'h06);
    e1 = cyc;
    repeat (1000) @(negedge clk);
    wreg(7'd10, 8'h26);
    e2 = cyc;
    chk("R11", strobe_n, 2, "no update while paused");
    while (strobe_n < 3) @(negedge clk);
    s3 = last_strobe;
    chk("R11", s3, e2 + TPS - (e1 - s2), "count resumes after pause");

    // R9 freeze
    wreg(7'd11, 8'h86);
    uh = uip_hi;
    while (cyc < s3 + TPS + 100) @(negedge clk);
    chk("R9", strobe_n, 3, "no update while frozen");
    chk("R9", uip_hi - uh, 0, "no uip while frozen");
    wreg(7'd11, 8'h06);
    while (strobe_n < 4) @(negedge clk);
    chk("R9", last_strobe - s3, 2 * TPS, "resume on original grid");
    chk("R8", dbl_strobe, 0, "strobe single cycle");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule